// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Timer

This block is a watchdog timer that software reaches through a small register window on a byte-addressed I/O bus with 16-bit accesses. Software sets a timeout in ticks, clears a halt bit to start counting, and keeps the system alive by writing anything to the reload register before the count runs out. A prescaler turns the system clock into ticks; one tick stands for roughly 0.6 s in a real system, and the default timeout values of interest run from 4 to 63 ticks.

The countdown has two stages. The first expiry only raises a status flag, reloads the counter and keeps counting. If the counter expires again while that flag is still set, the block raises a second status flag and pulses a system reset request for one clock, unless the no-reboot control bit is set. A halt bit freezes the countdown and the prescaler.

The register port is plain control: a write strobe with address and data, and a read data bus that shows the addressed register in the same cycle. There is no streaming data path, so no valid/ready handshake is used and the bus never back-pressures.

Top module: `wdt_top`

## Requirements
- R1: After reset the halt bit is 1, the no-reboot bit is 0, both status flags are 0, the timer register reads 0x0004, the count reads 4 and `rst_req` is 0.
- R2: A write of any data to offset 0x00 loads the count from the low 10 bits of the timer register on the next clock and restarts the prescaler; a read of offset 0x00 returns the count in bits [9:0]. A reload in the same cycle as a tick takes priority and no expiry happens.
- R3: The timer register at offset 0x12 stores all 16 written bits and reads them back; bits [9:0] are the timeout, used only at the next reload or expiry.
- R4: Bit 11 of the control register at offset 0x08 is the halt bit: while it is 1 the count and the prescaler hold; it reads back as written.
- R5: While not halted, the count decrements by one every `TICK_DIV` clocks.
- R6: A tick with the count at zero and status-1 bit 3 (offset 0x04) clear sets that bit, reloads the count from the timer field and keeps counting.
- R7: A tick with the count at zero and status-1 bit 3 already set sets status-2 bit 1 (offset 0x06), reloads the count, and, when control bit 0 (no-reboot) is 0, drives `rst_req` high for exactly one clock on the same edge.
- R8: Writing 1 to status-1 bit 3 or status-2 bit 1 clears that flag; writing 0 leaves it; a flag being set in the same cycle as its clear stays set.
- R9: Writes to offsets other than 0x00, 0x04, 0x06, 0x08 and 0x12 change nothing; reads of them return 0; control bits other than 11 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data of the register at `bus_addr`, combinational |
| rst_req | output | 1 | One-clock system reset request on a second expiry |

## Verification
The bound checker watches on every cycle that a reset request lasts one clock, only appears with the second flag set and the no-reboot bit clear, that the second flag only rises with the first already set, that a halted count never moves and that a reload lands the programmed value. What only the bench's scenarios show is the tick spacing set by the prescaler, the reset values, the write-one-to-clear behaviour including zero writes, the full 16-bit timer readback and the silence of the reserved offsets; the behavioural model in the bench compares read data and the reset request each clock across those scenarios.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFS_RELOAD  = 'h00;
  localparam int OFS_STAT1   = 'h04;
  localparam int OFS_STAT2   = 'h06;
  localparam int OFS_CTRL    = 'h08;
  localparam int OFS_TIMER   = 'h12;

  localparam int BIT_FIRST   = 3;
  localparam int BIT_SECOND  = 1;
  localparam int BIT_HALT    = 11;
  localparam int BIT_NOBOOT  = 0;

  localparam int TIMER_RESET = 4;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_DIV = 150000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q;

  assign tick = run && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (run) begin
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W     = 10,
  parameter int RESET_VAL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  input  logic             no_reboot,
  input  logic             clr_first,
  input  logic             clr_second,
  output logic [CNT_W-1:0] cnt,
  output logic             first,
  output logic             second,
  output logic             rst_req
);
  logic expire, set_first, set_second;

  assign expire     = tick && !reload && (cnt == '0);
  assign set_first  = expire && !first;
  assign set_second = expire && first;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(RESET_VAL);
    end else if (reload || expire) begin
      cnt <= load_val;
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first   <= 1'b0;
      second  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      first   <= (first  && !clr_first)  || set_first;
      second  <= (second && !clr_second) || set_second;
      rst_req <= set_second && !no_reboot;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 150000000,
  parameter int CNT_W    = 10,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic              hit_reload, hit_stat1, hit_stat2, hit_ctrl, hit_timer;
  logic              sel_rld, sel_s1, sel_s2, sel_ctl, sel_tmr;
  logic [DATA_W-1:0] tmr_q;
  logic              halt_q, nrb_q;
  logic              tick;
  logic [CNT_W-1:0]  cnt;
  logic              first, second;

  assign hit_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
  assign hit_stat1  = (bus_addr == ADDR_W'(OFS_STAT1));
  assign hit_stat2  = (bus_addr == ADDR_W'(OFS_STAT2));
  assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_timer  = (bus_addr == ADDR_W'(OFS_TIMER));

  assign sel_rld = bus_wr && hit_reload;
  assign sel_s1  = bus_wr && hit_stat1;
  assign sel_s2  = bus_wr && hit_stat2;
  assign sel_ctl = bus_wr && hit_ctrl;
  assign sel_tmr = bus_wr && hit_timer;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q  <= DATA_W'(TIMER_RESET);
      halt_q <= 1'b1;
      nrb_q  <= 1'b0;
    end else begin
      if (sel_tmr) tmr_q <= bus_wdata;
      if (sel_ctl) begin
        halt_q <= bus_wdata[BIT_HALT];
        nrb_q  <= bus_wdata[BIT_NOBOOT];
      end
    end
  end

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (!halt_q),
    .restart (sel_rld),
    .tick    (tick)
  );

  wdt_countdown #(.CNT_W(CNT_W), .RESET_VAL(TIMER_RESET)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .reload     (sel_rld),
    .load_val   (tmr_q[CNT_W-1:0]),
    .no_reboot  (nrb_q),
    .clr_first  (sel_s1 && bus_wdata[BIT_FIRST]),
    .clr_second (sel_s2 && bus_wdata[BIT_SECOND]),
    .cnt        (cnt),
    .first      (first),
    .second     (second),
    .rst_req    (rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_reload) bus_rdata = {{PAD_W{1'b0}}, cnt};
    if (hit_stat1)  bus_rdata[BIT_FIRST]  = first;
    if (hit_stat2)  bus_rdata[BIT_SECOND] = second;
    if (hit_ctrl) begin
      bus_rdata[BIT_HALT]   = halt_q;
      bus_rdata[BIT_NOBOOT] = nrb_q;
    end
    if (hit_timer)  bus_rdata = tmr_q;
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             reload,
  input logic             halt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val,
  input logic             first,
  input logic             second,
  input logic             no_reboot,
  input logic             rst_req
);
  AST_RST_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R7
  AST_RST_WITH_SECOND: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> second); // R7
  AST_RST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !$past(no_reboot)); // R7
  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(second) |-> $past(first)); // R7
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (halt && !reload) |=> $stable(cnt)); // R4
  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt == $past(load_val))); // R2
endmodule

bind wdt_top wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reload    (sel_rld),
  .halt      (halt_q),
  .cnt       (cnt),
  .load_val  (tmr_q[CNT_W-1:0]),
  .first     (first),
  .second    (second),
  .no_reboot (nrb_q),
  .rst_req   (rst_req)
);

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_top #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  // behavioural reference
  int m_pre, m_cnt, m_tmr;
  bit m_f1, m_f2, m_halt, m_nrb, m_rst;

  always @(posedge clk) begin
    bit ld, tk, s1, s2;
    if (rst) begin
      m_pre = 0; m_cnt = 4; m_tmr = 4; m_f1 = 0; m_f2 = 0;
      m_halt = 1; m_nrb = 0; m_rst = 0;
    end else begin
      ld = bus_wr && bus_addr == 8'h00;
      tk = !m_halt && m_pre == DIV - 1;
      if (ld) m_pre = 0;
      else if (!m_halt) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      s1 = 0; s2 = 0; m_rst = 0;
      if (ld) m_cnt = m_tmr % 1024;
      else if (tk) begin
        if (m_cnt == 0) begin
          m_cnt = m_tmr % 1024;
          if (!m_f1) s1 = 1;
          else begin s2 = 1; m_rst = !m_nrb; end
        end else m_cnt = m_cnt - 1;
      end
      if (bus_wr && bus_addr == 8'h04 && bus_wdata[3]) m_f1 = 0;
      if (bus_wr && bus_addr == 8'h06 && bus_wdata[1]) m_f2 = 0;
      if (s1) m_f1 = 1;
      if (s2) m_f2 = 1;
      if (bus_wr && bus_addr == 8'h12) m_tmr = bus_wdata;
      if (bus_wr && bus_addr == 8'h08) begin
        m_halt = bus_wdata[11]; m_nrb = bus_wdata[0];
      end
    end
  end

  function automatic int exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_cnt;
      8'h04: return m_f1 ? 16'h0008 : 16'h0000;
      8'h06: return m_f2 ? 16'h0002 : 16'h0000;
      8'h08: return (m_halt ? 16'h0800 : 16'h0000) | (m_nrb ? 16'h0001 : 16'h0000);
      8'h12: return m_tmr;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      case (bus_addr)
        8'h00:        chk("R5 count vs model", int'(bus_rdata), exp_read(bus_addr));
        8'h04, 8'h06: chk("R8 status vs model", int'(bus_rdata), exp_read(bus_addr));
        8'h08:        chk("R4 control vs model", int'(bus_rdata), exp_read(bus_addr));
        8'h12:        chk("R3 timer vs model", int'(bus_rdata), exp_read(bus_addr));
        default:      chk("R9 reserved vs model", int'(bus_rdata), exp_read(bus_addr));
      endcase
      chk("R7 rst_req vs model", int'(rst_req), int'(m_rst));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, v2, pulses, width;
    bit seen;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    rd(8'h00, v); chk("R1 count", v, 4);
    rd(8'h04, v); chk("R1 status-1", v, 0);
    rd(8'h06, v); chk("R1 status-2", v, 0);
    rd(8'h08, v); chk("R1 control", v, 16'h0800);
    rd(8'h12, v); chk("R1 timer", v, 4);
    chk("R1 rst_req", int'(rst_req), 0);

    // R3 full readback, deferred effect
    wr(8'h12, 16'hFC05);
    rd(8'h12, v); chk("R3 timer readback", v, 16'hFC05);
    rd(8'h00, v); chk("R3 count unchanged before reload", v, 4);

    // R2 reload with arbitrary data
    wr(8'h00, 16'hBEEF);
    rd(8'h00, v); chk("R2 reload value", v, 5);

    // R5 tick spacing: start counting, count drops after DIV clocks
    wr(8'h00, 16'h0000);
    wr(8'h08, 16'h0000);
    bus_addr = 8'h00;
    @(negedge clk); v = int'(bus_rdata);
    repeat (DIV) @(negedge clk);
    chk("R5 one decrement per DIV clocks", v - int'(bus_rdata), 1);

    // R6 first expiry
    seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(posedge clk); #1 bus_addr = 8'h04;
      @(negedge clk); if (bus_rdata[3]) seen = 1;
    end
    chk("R6 first flag set", int'(seen), 1);
    rd(8'h06, v); chk("R6 second flag still clear", v, 0);

    // R7 second expiry with reset pulse
    bus_addr = 8'h00;
    pulses = 0; width = 0;
    for (int i = 0; i < 200 && pulses == 0; i++) begin
      @(negedge clk); if (rst_req) pulses++;
    end
    chk("R7 reset pulse seen", pulses, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); if (rst_req) width++;
    end
    chk("R7 pulse lasts one clock", width, 0);
    rd(8'h06, v); chk("R7 second flag set", v, 16'h0002);

    // R4 halt freezes count
    wr(8'h08, 16'h0800);
    rd(8'h00, v);
    repeat (20) @(negedge clk);
    rd(8'h00, v2); chk("R4 halted count stable", v2, v);
    rd(8'h08, v); chk("R4 halt readback", v, 16'h0800);

    // R8 write-one-to-clear
    wr(8'h04, 16'hFFF7);
    rd(8'h04, v); chk("R8 zero write keeps first", v, 16'h0008);
    wr(8'h06, 16'hFFFD);
    rd(8'h06, v); chk("R8 zero write keeps second", v, 16'h0002);
    wr(8'h04, 16'h0008);
    rd(8'h04, v); chk("R8 clear first", v, 0);
    wr(8'h06, 16'h0002);
    rd(8'h06, v); chk("R8 clear second", v, 0);

    // R9 reserved offsets
    wr(8'h02, 16'hFFFF);
    wr(8'h0A, 16'hFFFF);
    wr(8'h13, 16'hFFFF);
    wr(8'h05, 16'hFFFF);
    rd(8'h02, v); chk("R9 reserved reads zero", v, 0);
    rd(8'h13, v); chk("R9 reserved reads zero", v, 0);
    rd(8'h08, v); chk("R9 control untouched", v, 16'h0800);
    rd(8'h12, v); chk("R9 timer untouched", v, 16'hFC05);
    rd(8'h04, v); chk("R9 status untouched", v, 0);
    wr(8'h08, 16'hFFFF);
    rd(8'h08, v); chk("R9 unused control bits read zero", v, 16'h0801);

    // R7 no-reboot suppresses the request
    wr(8'h12, 16'h0002);
    wr(8'h00, 16'h1234);
    wr(8'h08, 16'h0001);
    bus_addr = 8'h06;
    pulses = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); if (rst_req) pulses++;
    end
    chk("R7 no-reboot blocks reset", pulses, 0);
    rd(8'h06, v); chk("R7 second flag despite no-reboot", v, 16'h0002);
    rd(8'h08, v); chk("R7 no-reboot readback", v, 16'h0001);

    // R2 repeated reloads keep the count from expiring
    wr(8'h04, 16'h0008);
    wr(8'h06, 16'h0002);
    for (int i = 0; i < 10; i++) wr(8'h00, 16'h0000);
    rd(8'h04, v); chk("R2 fed watchdog no expiry", v, 0);

    wr(8'h08, 16'h0800);
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule